// File: doc/BRIEF.md
# Command-Stream Register Write Decoder

This block sits on a byte-wide valid/ready stream, such as one fed from a bulk transport, and turns register-write commands in it into updates of a bank of display-controller registers. The registers it drives are the colour-depth selector, two 24-bit frame-buffer base addresses, twelve 16-bit timing comparators, a pixel-clock word and the blank mode. Every command opens with the header byte 0xAF and a code byte. Only the register-write code is executed. Any other code makes the decoder abandon the command and wait for the next header, so pixel-copy and render commands are skipped and not carried out.

Video registers can be staged. A write of 0x00 to the lock address 0xFF diverts later writes into shadow storage. A write of 0xFF to the same address copies every shadow byte into the live registers on one clock edge, so a full mode change appears at the outputs all at once. Multi-byte fields do not share one byte order: the timing words and base addresses store their most significant byte first, and the pixel-clock word stores its least significant byte first.

Top module: `vidcmd_decoder`

## Requirements
- R1: A register write is the four accepted bytes 0xAF, 0x20, address, data. `in_ready` is always high, a byte is accepted on each rising edge where `in_valid` is high, cycles with `in_valid` low change nothing, and the write shows at the outputs one cycle after the data byte is accepted.
- R2: When a command is expected, any byte other than 0xAF is discarded and changes no output.
- R3: A code byte other than 0x20 (0xAF included) ends the command. Bytes up to the next 0xAF header are discarded, and the decoder then decodes normally from that header.
- R4: Writing 0x00 to address 0xFF sets `regs_locked`. While it is set, register writes change no register output.
- R5: Writing 0xFF to address 0xFF clears `regs_locked` and makes all staged writes visible on the same cycle. Unlocking while already unlocked changes nothing, and any other data byte written to 0xFF is ignored.
- R6: `timing[i]` (i = 0..11) takes its high byte from address 0x01+2i and its low byte from address 0x02+2i.
- R7: `pix_clk` takes its low byte from address 0x1B and its high byte from address 0x1C.
- R8: `base16` is {0x20, 0x21, 0x22} and `base8` is {0x26, 0x27, 0x28}, with the most significant byte first in each.
- R9: `depth_sel` is the byte at address 0x00 (0 = 16 bpp, 1 = 24 bpp). `blank_mode` is the byte at address 0x1F.
- R10: After reset every register output is zero and `regs_locked` is low. Writes to addresses that are not listed in R6 to R9 (for example 0x19, 0x1D, 0x23, 0x80) change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Always high |
| regs_locked | output | 1 | Staging active |
| depth_sel | output | 8 | Colour-depth selector |
| blank_mode | output | 8 | Blank / sync mode |
| timing | output | 12x16 | Timing comparator words |
| pix_clk | output | 16 | Pixel-clock word |
| base16 | output | 24 | 16 bpp frame-buffer base |
| base8 | output | 24 | 8 bpp frame-buffer base |

## Verification
A sweep writes every address from 0x00 to 0xFE in turn. Each write must land in exactly the field byte that R6 to R9 assign to it, or in no field at all, and this exposes swapped byte orders, shifted offsets and any alias onto an unlisted address. Stray bytes, wrong codes and an extra header byte placed between commands test whether the parser drops to the idle state and picks up again at the next header. Gaps in `in_valid` test that nothing advances on idle cycles. A locked phase writes over many fields, checks that no output moves, and then checks that all of them change together on the unlock write. This separates true staging from direct writes and from partial commits.

// File: rtl/vidcmd_decoder.sv
module vidcmd_decoder (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              regs_locked,
  output logic [7:0]        depth_sel,
  output logic [7:0]        blank_mode,
  output logic [11:0][15:0] timing,
  output logic [15:0]       pix_clk,
  output logic [23:0]       base16,
  output logic [23:0]       base8
);
  localparam logic [7:0] HDR      = 8'hAF;
  localparam logic [7:0] WR_CODE  = 8'h20;
  localparam logic [7:0] LOCK_REG = 8'hFF;
  localparam int         NREG     = 34;

  typedef enum logic [1:0] {S_IDLE, S_CODE, S_ADDR, S_DATA} st_t;

  st_t        st;
  logic [7:0] addr;
  logic       locked;
  logic [7:0] sh [NREG];
  logic [7:0] ac [NREG];
  logic       hit;
  logic [5:0] idx;

  function automatic logic [6:0] slot(input logic [7:0] a);
    if (a <= 8'h18) return {1'b1, a[5:0]};
    case (a)
      8'h1B:   return {1'b1, 6'd25};
      8'h1C:   return {1'b1, 6'd26};
      8'h1F:   return {1'b1, 6'd27};
      8'h20:   return {1'b1, 6'd28};
      8'h21:   return {1'b1, 6'd29};
      8'h22:   return {1'b1, 6'd30};
      8'h26:   return {1'b1, 6'd31};
      8'h27:   return {1'b1, 6'd32};
      8'h28:   return {1'b1, 6'd33};
      default: return 7'd0;
    endcase
  endfunction

  assign {hit, idx} = slot(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      locked <= 1'b0;
      for (int k = 0; k < NREG; k++) begin
        sh[k] <= '0;
        ac[k] <= '0;
      end
    end else if (in_valid) begin
      case (st)
        S_IDLE: if (in_data == HDR) st <= S_CODE;
        S_CODE: st <= (in_data == WR_CODE) ? S_ADDR : S_IDLE;
        S_ADDR: begin
          addr <= in_data;
          st   <= S_DATA;
        end
        S_DATA: begin
          st <= S_IDLE;
          if (addr == LOCK_REG) begin
            if (in_data == 8'h00) locked <= 1'b1;
            else if (in_data == 8'hFF) begin
              locked <= 1'b0;
              for (int k = 0; k < NREG; k++) ac[k] <= sh[k];
            end
          end else if (hit) begin
            sh[idx] <= in_data;
            if (!locked) ac[idx] <= in_data;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < 12; i++) begin : g_tim
    assign timing[i] = {ac[1 + 2*i], ac[2 + 2*i]};
  end

  assign in_ready    = 1'b1;
  assign regs_locked = locked;
  assign depth_sel   = ac[0];
  assign pix_clk     = {ac[26], ac[25]};
  assign blank_mode  = ac[27];
  assign base16      = {ac[28], ac[29], ac[30]};
  assign base8       = {ac[31], ac[32], ac[33]};
endmodule

// File: rtl/vidcmd_decoder_chk.sv
module vidcmd_decoder_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        in_data,
  input logic [1:0]        st,
  input logic [7:0]        addr,
  input logic              regs_locked,
  input logic [7:0]        depth_sel,
  input logic [7:0]        blank_mode,
  input logic [11:0][15:0] timing,
  input logic [15:0]       pix_clk,
  input logic [23:0]       base16,
  input logic [23:0]       base8
);
  localparam logic [1:0] C_IDLE = 2'd0;
  localparam logic [1:0] C_CODE = 2'd1;
  localparam logic [1:0] C_DATA = 2'd3;

  a_r1_hdr_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && in_valid && in_data == 8'hAF) |=> st == C_CODE);

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(st));

  a_r2_drop_stray: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && in_valid && in_data != 8'hAF) |=> st == C_IDLE);

  a_r3_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_CODE && in_valid && in_data != 8'h20) |=> st == C_IDLE);

  a_r4_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DATA && in_valid && addr == 8'hFF && in_data == 8'h00) |=> regs_locked);

  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    regs_locked |=> (!regs_locked ||
      ($stable(timing) && $stable(pix_clk) && $stable(base16) && $stable(base8) &&
       $stable(depth_sel) && $stable(blank_mode))));

  a_r5_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DATA && in_valid && addr == 8'hFF && in_data == 8'hFF) |=> !regs_locked);

  a_r9_depth_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DATA && in_valid && !regs_locked && addr == 8'h00) |=> depth_sel == $past(in_data));
endmodule

bind vidcmd_decoder vidcmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .st(st), .addr(addr), .regs_locked(regs_locked), .depth_sel(depth_sel),
  .blank_mode(blank_mode), .timing(timing), .pix_clk(pix_clk),
  .base16(base16), .base8(base8)
);

// File: tb/vidcmd_decoder_tb.sv
module vidcmd_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready, regs_locked;
  logic [7:0]        depth_sel, blank_mode;
  logic [11:0][15:0] timing;
  logic [15:0]       pix_clk;
  logic [23:0]       base16, base8;

  int total = 0;
  int bad = 0;
  logic [7:0] sh_m [256];
  logic [7:0] ac_m [256];
  logic       lk_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidcmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .regs_locked(regs_locked), .depth_sel(depth_sel),
    .blank_mode(blank_mode), .timing(timing), .pix_clk(pix_clk),
    .base16(base16), .base8(base8)
  );

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h00;
  endtask

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hFF) begin
      if (d == 8'h00) lk_m = 1'b1;
      else if (d == 8'hFF) begin
        lk_m = 1'b0;
        for (int k = 0; k < 256; k++) ac_m[k] = sh_m[k];
      end
    end else begin
      sh_m[a] = d;
      if (!lk_m) ac_m[a] = d;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    put(8'hAF); put(8'h20); put(a); put(d); gap();
    model_wr(a, d);
  endtask

  task automatic check_all(input string tag);
    logic [272:0] act, exp;
    logic [191:0] tx;
    for (int i = 0; i < 12; i++)
      tx[i*16 +: 16] = {ac_m[8'(1 + 2*i)], ac_m[8'(2 + 2*i)]};
    exp = {tx, ac_m[8'h1C], ac_m[8'h1B], ac_m[8'h20], ac_m[8'h21], ac_m[8'h22],
           ac_m[8'h26], ac_m[8'h27], ac_m[8'h28], ac_m[8'h00], ac_m[8'h1F], lk_m};
    act = {timing, pix_clk, base16, base8, depth_sel, blank_mode, regs_locked};
    total++;
    if (act !== exp || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h ready=%b", tag, act, exp, in_ready);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) begin
      sh_m[k] = '0;
      ac_m[k] = '0;
    end
    lk_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10 reset");

    // R6 R7 R8 R9 R10: write every address once, unlocked
    for (int a = 0; a < 255; a++) begin
      wr(8'(a), 8'(a * 37 + 11));
      check_all("R1 R6 R7 R8 R9 R10 sweep");
    end

    // R2: stray bytes at a command boundary
    put(8'h20); put(8'h01); put(8'h55); put(8'h00); gap();
    check_all("R2 stray bytes");

    // R3: bad codes, including a repeated header
    put(8'hAF); put(8'h21); put(8'h01); put(8'h77); gap();
    check_all("R3 bad code 0x21");
    put(8'hAF); put(8'h6A); put(8'h20); put(8'h05); put(8'h99); gap();
    check_all("R3 copy command skipped");
    put(8'hAF); put(8'hAF); put(8'h20); put(8'h1F); put(8'h44); gap();
    check_all("R3 header as code");
    wr(8'h1F, 8'h33);
    check_all("R3 resync write");

    // R1: gaps in in_valid between command bytes
    put(8'hAF); gap(); put(8'h20); gap(); gap(); put(8'h09); gap();
    check_all("R1 gap before data");
    put(8'hBE); gap();
    model_wr(8'h09, 8'hBE);
    check_all("R1 gapped write");

    // R4: lock and write many fields
    wr(8'hFF, 8'h00);
    check_all("R4 lock set");
    for (int a = 0; a < 41; a++) begin
      wr(8'(a), 8'(a * 91 + 200));
      check_all("R4 locked hold");
    end
    wr(8'hFF, 8'h12);
    check_all("R5 other data ignored");
    wr(8'hFF, 8'h00);
    check_all("R4 relock");

    // R5: commit all at once
    wr(8'hFF, 8'hFF);
    check_all("R5 unlock commit");
    wr(8'hFF, 8'hFF);
    check_all("R5 unlock when unlocked");
    wr(8'h00, 8'h01);
    check_all("R9 direct after unlock");

    // R7 R8: byte order of the multi-byte fields
    wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
    total++;
    if (pix_clk !== 16'h1234) begin
      bad++;
      $display("FAIL R7: act=%h exp=1234", pix_clk);
    end
    wr(8'h20, 8'hAB); wr(8'h21, 8'hCD); wr(8'h22, 8'hEF);
    total++;
    if (base16 !== 24'hABCDEF) begin
      bad++;
      $display("FAIL R8: act=%h exp=abcdef", base16);
    end
    wr(8'h01, 8'h02); wr(8'h02, 8'h80);
    total++;
    if (timing[0] !== 16'h0280) begin
      bad++;
      $display("FAIL R6: act=%h exp=0280", timing[0]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule